// File: doc/BRIEF.md
# DDS Phase Generator with Register Bank

This block is the numerically controlled phase source for a direct digital synthesizer. A 32-bit accumulator advances on every clock by one of two 32-bit tuning words, so the output frequency is the tuning word divided by 2^32, times the clock frequency. A 12-bit phase offset, chosen from four offset registers, is added to the top twelve accumulator bits. The result is registered as the output phase word, which a later sine lookup stage consumes.

Software loads the tuning words and offsets through a 16-bit parallel write port with a 3-bit address. A tuning word is written as two 16-bit halves. An offset register takes only the low twelve data bits. The `freq_sel` and `phase_sel` inputs are sampled on every clock. Hopping between frequencies or phases therefore takes effect at once, with no gap and no restart of the accumulator.

Top module: `dds_phase_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, both tuning words and all four offsets are cleared to zero, and after that edge `phase_out` is 0 and `phase_vld` is 0.
- R2: At each rising edge out of reset, the accumulator becomes its previous value plus the selected tuning word, modulo 2^32, with no saturation.
- R3: `freq_sel` = 0 selects tuning word 0 as the increment, and `freq_sel` = 1 selects tuning word 1. The input is sampled at every edge.
- R4: A write at a rising edge with `wr_en` = 1 stores `wr_data` by `wr_addr`: 0 = tuning word 0 bits [15:0], 1 = tuning word 0 bits [31:16], 2 = tuning word 1 bits [15:0], 3 = tuning word 1 bits [31:16], 4..7 = offset 0..3. All other register contents are left unchanged.
- R5: A write to an offset register stores `wr_data[11:0]` and ignores `wr_data[15:12]`.
- R6: `phase_sel` (bit 1 = high select, bit 0 = low select) picks the offset: 00 = offset 0, 01 = offset 1, 10 = offset 2, 11 = offset 3.
- R7: `phase_out` after an edge equals the accumulator bits [31:20] held before that edge, plus the offset selected before that edge, modulo 2^12. The offset never enters the accumulator state.
- R8: A register written at edge k is used by the accumulator update or the output at edge k+1. `phase_vld` is 1 after every edge at which `rst_n` is high.
- R9: Changing `freq_sel` or `phase_sel` between cycles causes no gap in `phase_vld` and does not reset the accumulator.
- R10: With tuning word 0x547AE148 (about 16.5 MHz at a 50 MHz clock), the count of accumulator wraps over N cycles equals floor((start + N·word) / 2^32), which is about 0.33·N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_addr | input | 3 | Destination register select |
| wr_data | input | 16 | Write data |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 2 | Phase offset select |
| phase_out | output | 12 | Output phase word |
| phase_vld | output | 1 | Output phase word valid |

## Verification
The phase path is first driven with directed patterns:
- Single-half tuning writes and an all-ones tuning word separate a correct modulo-2^32 carry from saturation or a lost upper half.
- Offsets written with the high nibble set show whether `wr_data[15:12]` leaks into the offset.
- Sweeping `phase_sel` through all four codes separates a swapped select bit from a correct decode.

Long random runs then mix writes with `freq_sel` and `phase_sel` hopping on every cycle. These runs show whether the offset is kept out of the accumulator, and whether a write lands one cycle early or late. A long run with the 0x547AE148 word checks the carry rate against the expected count of 16.5 MHz cycles.

// File: rtl/dds_pkg.sv
// Package: shared sizes for the DDS phase generator.
// Assumes the tuning word is exactly two write-port words wide.
package dds_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ACC_W   = 32;
    localparam int unsigned PH_W    = 12;
    localparam int unsigned N_FREQ  = 2;
    localparam int unsigned N_PHASE = 4;
    localparam int unsigned ADDR_W  = 3;
endpackage

// File: rtl/dds_regbank.sv
// Module: dds_regbank
// Holds the tuning words (each loaded in two halves) and the phase
// offsets, and presents the currently selected increment and offset.
// Assumes ACC_W == 2*DATA_W, N_FREQ == 2 and N_PHASE == 4. Address bit
// 2 chooses the offset bank, and in the tuning bank bit 1 is the word
// and bit 0 the half.
module dds_regbank #(
    parameter int unsigned DATA_W  = dds_pkg::DATA_W,
    parameter int unsigned ACC_W   = dds_pkg::ACC_W,
    parameter int unsigned PH_W    = dds_pkg::PH_W,
    parameter int unsigned N_FREQ  = dds_pkg::N_FREQ,
    parameter int unsigned N_PHASE = dds_pkg::N_PHASE,
    parameter int unsigned ADDR_W  = dds_pkg::ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             freq_sel,
    input  logic [1:0]                       phase_sel,
    output logic [N_FREQ-1:0][ACC_W-1:0]     freq_q,
    output logic [N_PHASE-1:0][PH_W-1:0]     poff_q,
    output logic [ACC_W-1:0]                 inc,
    output logic [PH_W-1:0]                  off
);
    localparam int unsigned HALF_W = ACC_W / 2;

    logic in_phase_bank;
    assign in_phase_bank = wr_addr[ADDR_W-1];

    for (genvar f = 0; f < N_FREQ; f++) begin : g_freq
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic hit;
            assign hit = wr_en && !in_phase_bank
                         && (wr_addr[1] == f[0]) && (wr_addr[0] == h[0]);
            // Load one half of a tuning word when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    freq_q[f][h*HALF_W +: HALF_W] <= '0;
                else if (hit)
                    freq_q[f][h*HALF_W +: HALF_W] <= wr_data[HALF_W-1:0];
            end
        end
    end

    for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
        logic hit;
        assign hit = wr_en && in_phase_bank && (wr_addr[1:0] == p[1:0]);
        // Load an offset register from the low data bits only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                poff_q[p] <= '0;
            else if (hit)
                poff_q[p] <= wr_data[PH_W-1:0];
        end
    end

    // Pick the increment and offset named by the select inputs.
    always_comb begin
        inc = freq_q[freq_sel];
        off = poff_q[phase_sel];
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Free-running phase accumulator that adds the increment on every
// clock and wraps modulo 2^ACC_W. It assumes the increment is stable
// at each rising edge.
module dds_phase_acc #(
    parameter int unsigned ACC_W = dds_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] acc_q
);
    // Advance the phase by the increment, dropping the carry out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_q + inc;
    end
endmodule

// File: rtl/dds_offset_add.sv
// Module: dds_offset_add
// Adds the selected phase offset to the accumulator's top bits and
// registers the wrapped sum, together with a valid flag. It assumes
// acc_top already holds the top PH_W accumulator bits.
module dds_offset_add #(
    parameter int unsigned PH_W = dds_pkg::PH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] acc_top,
    input  logic [PH_W-1:0] off,
    output logic [PH_W-1:0] phase_out,
    output logic            phase_vld
);
    // Register the modulo-2^PH_W phase sum and mark it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out <= '0;
            phase_vld <= 1'b0;
        end else begin
            phase_out <= acc_top + off;
            phase_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/dds_phase_gen.sv
// Module: dds_phase_gen (top)
// Phase generator for a direct digital synthesizer. It has a write
// register bank, a 32-bit accumulator and an offset adder with a
// registered output. All state is reset synchronously while rst_n is low.
module dds_phase_gen #(
    parameter int unsigned DATA_W  = dds_pkg::DATA_W,
    parameter int unsigned ACC_W   = dds_pkg::ACC_W,
    parameter int unsigned PH_W    = dds_pkg::PH_W,
    parameter int unsigned N_FREQ  = dds_pkg::N_FREQ,
    parameter int unsigned N_PHASE = dds_pkg::N_PHASE,
    parameter int unsigned ADDR_W  = dds_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              freq_sel,
    input  logic [1:0]        phase_sel,
    output logic [PH_W-1:0]   phase_out,
    output logic              phase_vld
);
    logic [N_FREQ-1:0][ACC_W-1:0]  freq_w;
    logic [N_PHASE-1:0][PH_W-1:0]  poff_w;
    logic [ACC_W-1:0]              inc_w;
    logic [PH_W-1:0]               off_w;
    logic [ACC_W-1:0]              acc_w;

    dds_regbank #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .PH_W(PH_W),
        .N_FREQ(N_FREQ), .N_PHASE(N_PHASE), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freq_sel(freq_sel), .phase_sel(phase_sel),
        .freq_q(freq_w), .poff_q(poff_w), .inc(inc_w), .off(off_w)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .inc(inc_w), .acc_q(acc_w)
    );

    dds_offset_add #(.PH_W(PH_W)) add_i (
        .clk(clk), .rst_n(rst_n), .acc_top(acc_w[ACC_W-1 -: PH_W]),
        .off(off_w), .phase_out(phase_out), .phase_vld(phase_vld)
    );
endmodule

// File: rtl/dds_phase_gen_chk.sv
// Module: dds_phase_gen_chk
// Temporal checks on the phase generator, bound into every instance of
// the top module. It reads the top's ports and its inter-module nets.
module dds_phase_gen_chk #(
    parameter int unsigned DATA_W  = dds_pkg::DATA_W,
    parameter int unsigned ACC_W   = dds_pkg::ACC_W,
    parameter int unsigned PH_W    = dds_pkg::PH_W,
    parameter int unsigned N_FREQ  = dds_pkg::N_FREQ,
    parameter int unsigned N_PHASE = dds_pkg::N_PHASE,
    parameter int unsigned ADDR_W  = dds_pkg::ADDR_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [PH_W-1:0]               phase_out,
    input logic                          phase_vld,
    input logic [N_FREQ-1:0][ACC_W-1:0]  freq_w,
    input logic [N_PHASE-1:0][PH_W-1:0]  poff_w,
    input logic [ACC_W-1:0]              inc_w,
    input logic [PH_W-1:0]               off_w,
    input logic [ACC_W-1:0]              acc_w
);
    // R2: the accumulator steps by the increment held before the edge.
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_w == $past(acc_w) + $past(inc_w));

    // R4: a low-half write to tuning word 0 leaves its high half alone.
    p_freq_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=>
        (freq_w[0][15:0] == $past(wr_data)) &&
        (freq_w[0][31:16] == $past(freq_w[0][31:16])));

    // R5: an offset write keeps only the low data bits.
    p_poff_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2]) |=>
        poff_w[$past(wr_addr[1:0])] == $past(wr_data[PH_W-1:0]));

    // R7: the output is the top accumulator bits plus the chosen offset.
    p_phase_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        phase_out == PH_W'($past(acc_w[ACC_W-1 -: PH_W]) + $past(off_w)));

    // R8: the valid flag stays high once reset has been released.
    p_vld_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase_vld);
endmodule

bind dds_phase_gen dds_phase_gen_chk #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .PH_W(PH_W),
    .N_FREQ(N_FREQ), .N_PHASE(N_PHASE), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/dds_phase_gen_tb_top.sv
// Bench for dds_phase_gen. It checks each output against a reference
// model that is stepped in lockstep with the clock.
module dds_phase_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        freq_sel = 1'b0;
    logic [1:0]  phase_sel = '0;
    logic [11:0] phase_out;
    logic        phase_vld;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    // Reference model state.
    logic [31:0] m_freq [2];
    logic [11:0] m_off  [4];
    logic [31:0] m_acc;
    logic [31:0] m_acc_out;
    logic [11:0] m_exp;
    logic        m_vld;

    always #5 clk = ~clk;

    dds_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freq_sel(freq_sel), .phase_sel(phase_sel),
        .phase_out(phase_out), .phase_vld(phase_vld)
    );

    function automatic logic [11:0] exp_phase(logic [31:0] a, logic [11:0] o);
        return a[31:20] + o;
    endfunction

    task automatic check(string req, logic ok, string what,
                         logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, step the model, compare after the rising edge.
    task automatic cyc(string req, logic rst, logic we, logic [2:0] a,
                       logic [15:0] d, logic fs, logic [1:0] ps);
        @(negedge clk);
        rst_n = rst; wr_en = we; wr_addr = a; wr_data = d;
        freq_sel = fs; phase_sel = ps;
        if (!rst) begin
            m_exp = '0; m_vld = 1'b0; m_acc = '0; m_acc_out = '0;
            m_freq[0] = '0; m_freq[1] = '0;
            for (int i = 0; i < 4; i++) m_off[i] = '0;
        end else begin
            m_exp = exp_phase(m_acc, m_off[ps]);
            m_vld = 1'b1;
            m_acc_out = m_acc;
            m_acc = m_acc + m_freq[fs];
            if (we) begin
                if (a[2]) m_off[a[1:0]] = d[11:0];
                else if (a[0]) m_freq[a[1]][31:16] = d;
                else m_freq[a[1]][15:0] = d;
            end
        end
        @(posedge clk);
        #1;
        check(req, phase_out === m_exp && phase_vld === m_vld, "phase/vld",
              {19'd0, phase_vld, phase_out}, {19'd0, m_vld, m_exp});
    endtask

    task automatic idle(string req, int n, logic fs, logic [1:0] ps);
        for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, 3'd0, 16'd0, fs, ps);
    endtask

    task automatic wr(string req, logic [2:0] a, logic [15:0] d);
        cyc(req, 1'b1, 1'b1, a, d, freq_sel, phase_sel);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] tot;
        int unsigned wraps;
        logic [11:0] prev;
        void'($urandom(32'd20240611));

        // R1: reset clears everything and holds the flag low.
        for (int i = 0; i < 3; i++) cyc("R1", 1'b0, 1'b1, 3'd1, 16'hFFFF, 1'b1, 2'd3);

        // R4/R8: a low half written now is used at the next update.
        wr("R4", 3'd0, 16'h0001);
        idle("R2", 4, 1'b0, 2'd0);
        wr("R4", 3'd1, 16'h0010);
        idle("R8", 4, 1'b0, 2'd0);

        // R5: the high data nibble is ignored on offset writes.
        wr("R5", 3'd4, 16'hF123);
        idle("R5", 2, 1'b0, 2'd0);

        // R6: each select code picks its own offset.
        wr("R6", 3'd5, 16'hA456);
        wr("R6", 3'd6, 16'h5789);
        wr("R6", 3'd7, 16'h0ABC);
        for (int p = 0; p < 4; p++) idle("R6", 2, 1'b0, 2'(p));

        // R3/R9: a second tuning word, selected back and forth.
        wr("R3", 3'd2, 16'h3333);
        wr("R3", 3'd3, 16'h0222);
        for (int i = 0; i < 8; i++) idle("R9", 1, 1'(i), 2'(i));

        // R2: an all-ones word wraps modulo 2^32 (a step of -1).
        wr("R2", 3'd0, 16'hFFFF);
        wr("R2", 3'd1, 16'hFFFF);
        idle("R2", 6, 1'b0, 2'd0);

        // R7/R9: random writes and select hopping.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc("R7", 1'b1, (r[3:0] == 4'd0), r[6:4], r[31:16], r[7], r[9:8]);
        end

        // R10: wrap rate of the 0x547AE148 word, offsets cleared.
        cyc("R1", 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, 2'd0);
        w = 32'h547AE148;
        wr("R10", 3'd0, w[15:0]);
        wr("R10", 3'd1, w[31:16]);
        idle("R10", 2, 1'b0, 2'd0);
        tot = {32'd0, m_acc_out} + 64'd1000 * {32'd0, w};
        wraps = 0;
        prev = phase_out;
        for (int i = 0; i < 1000; i++) begin
            idle("R10", 1, 1'b0, 2'd0);
            if (phase_out < prev) wraps++;
            prev = phase_out;
        end
        check("R10", wraps == 32'(tot >> 32), "wrap count", wraps, 32'(tot >> 32));
        check("R10", wraps >= 329 && wraps <= 331, "16.5MHz rate", wraps, 32'd330);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule